// File: doc/BRIEF.md
# Flash Bus-Side Mode and Reset Controller

This block sits on the bus side of a parallel NOR flash device and decides, on every clock, which operating mode the device is in. It watches the chip-select, output-enable and write-strobe inputs, the active-low hardware reset pin, the address bus, and a busy flag from the internal program/erase engine. From these it drives the data-output enable and a write-strobe forward to the command state machine. It also drives a load strobe and a valid flag for the read-data holding latch, the ready/busy output, and a level that holds the command state machine in array-read mode.

Every analog time is expressed as a count of clock cycles. The hardware reset pin has a minimum-width filter, so narrow glitches never abort an operation. An address that stays unchanged long enough puts the device into a low-power sleep state, and the held read data stays available while it sleeps. A mode code is brought out so that the state sequence can be compared against expectations. All inputs are taken to be synchronous to `clk`.

Top module: `flash_mode_ctrl`

## Requirements
- R1: With chip select high (`ce_n`=1), the reset pin high and no embedded operation running, `mode` is STANDBY (code 1) and `dout_oe` is 0 whatever `oe_n` is.
- R2: While `engine_busy` is 1, `ready` is 0, and a deselected device (`ce_n`=1) reports ACTIVE (code 0) instead of STANDBY until `engine_busy` falls.
- R3: Once the address has been sampled unchanged on SLEEP_CYC = T_ACC + SLEEP_MARGIN consecutive clock edges after the edge that captured it, a selected device reports SLEEP (code 2). The stability count ignores `we_n`, `oe_n` and `ce_n`.
- R4: In SLEEP, `data_valid` stays 1 and `dout_oe` follows `oe_n`. A new address ends SLEEP at the first edge that samples it and drops `data_valid`. `data_valid` returns T_ACC edges later, and `hold_load` pulses for the first cycle in which `data_valid` is 1.
- R5: Reselection after standby or sleep needs no wake-up delay. `data_valid` is 1 exactly T_ACC edges after `ce_n` is sampled low.
- R6: When `hw_reset_n` is sampled low on T_RP consecutive edges, `mode` becomes RESET (code 3) from that edge on and `cmd_reset` goes to 1. While the pin stays low, `dout_oe` and `wr_accept` are 0.
- R7: A low pulse on `hw_reset_n` that is shorter than T_RP edges causes no RESET mode and no `cmd_reset`, and leaves `ready` unchanged. Only while the pin is low are the outputs and write forwarding held off.
- R8: A valid reset pulse keeps `ready` at 0 for T_RDY_BUSY edges counted from the validating edge if `engine_busy` was 1 on that edge, and for T_RDY_IDLE edges otherwise.
- R9: After a valid reset pulse ends, `mode` is RECOVER (code 4) for T_RH edges. During that time `dout_oe` and `data_valid` are 0.
- R10: With `oe_n` high, `dout_oe` is 0 in every mode.
- R11: `wr_accept` is 1 exactly when `ce_n` and `we_n` are both low, the reset pin is high and the mode is not RESET. It is 1 during RECOVER.
- R12: After system reset (`rst_n` low on an edge), `cmd_reset` is 0, `ready` follows `engine_busy`, and the mode is STANDBY or ACTIVE according to `ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| hw_reset_n | input | 1 | Hardware reset pin, active low |
| addr | input | AW | Address bus |
| engine_busy | input | 1 | Program/erase engine is running |
| dout_oe | output | 1 | Drive the data pins (0 = high impedance) |
| wr_accept | output | 1 | Write strobe forwarded to the command state machine |
| data_valid | output | 1 | Held read data for the current address is valid |
| hold_load | output | 1 | One-cycle load strobe for the read-data latch |
| ready | output | 1 | Ready/busy output, 1 = ready |
| cmd_reset | output | 1 | Holds the command state machine in array-read mode |
| mode | output | 3 | Mode code: 0 ACTIVE, 1 STANDBY, 2 SLEEP, 3 RESET, 4 RECOVER |

## Verification
The assertions check on every cycle the per-cycle invariants. These are: output high impedance in standby, with `oe_n` high, in RESET and in RECOVER; write strobes blocked in RESET; ready held low while the engine is busy; and `cmd_reset` rising only after the pin has been low for T_RP edges. Some behaviour depends on exact counts and can only be shown by the bench scenarios. That covers the edge on which SLEEP begins, the T_ACC reselection access and the `hold_load` pulse. It also covers the choice between the two ready-completion times, the length of RECOVER, and the sweep of reset pulse widths on both sides of the minimum, each with and without a running operation.

// File: rtl/fmc_pkg.sv
// Package: shared mode encoding for the flash bus-side mode controller.
// Assumes: the numeric codes are visible on the top-level mode port.
package fmc_pkg;

    typedef enum logic [2:0] {
        FMC_ACTIVE  = 3'd0,
        FMC_STANDBY = 3'd1,
        FMC_SLEEP   = 3'd2,
        FMC_RESET   = 3'd3,
        FMC_RECOVER = 3'd4
    } fmc_mode_e;

endpackage

// File: rtl/fmc_access_mon.sv
// Module: fmc_access_mon
// Tracks address stability for automatic sleep and the access time of the
// current read. The address is captured every edge. A differing sample
// restarts both counters. The sleep counter runs independently of the bus
// strobes. The access counter only runs while the read path is selected.
// Assumes: addr is synchronous to clk; T_ACC >= 1; SLEEP_MARGIN >= 1.
module fmc_access_mon #(
    parameter int AW           = 4,
    parameter int T_ACC        = 3,
    parameter int SLEEP_MARGIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_sel,
    output logic          sleep_hit,
    output logic          data_valid,
    output logic          hold_load
);

    localparam int SLEEP_CYC = T_ACC + SLEEP_MARGIN;
    localparam int SW        = $clog2(SLEEP_CYC + 1);
    localparam int CW        = $clog2(T_ACC + 1);

    logic [AW-1:0] addr_q;
    logic [SW-1:0] stab_cnt;
    logic [CW-1:0] acc_cnt;
    logic          valid_q;
    logic          addr_moved;

    // Compare the live address against the last captured one.
    always_comb addr_moved = (addr != addr_q);

    // Capture the address and count edges on which it stayed unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stab_cnt <= '0;
        end else if (addr_moved) begin
            addr_q   <= addr;
            stab_cnt <= '0;
        end else if (stab_cnt != SW'(SLEEP_CYC)) begin
            stab_cnt <= stab_cnt + 1'b1;
        end
    end

    // Count access cycles of the selected read, restarting on any address move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
        end else if (addr_moved || !rd_sel) begin
            acc_cnt <= '0;
        end else if (acc_cnt != CW'(T_ACC)) begin
            acc_cnt <= acc_cnt + 1'b1;
        end
    end

    // Remember last cycle's valid flag to form the latch load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= data_valid;
        end
    end

    // Derive the sleep, valid and load indications from the counters.
    always_comb begin
        sleep_hit  = (stab_cnt == SW'(SLEEP_CYC));
        data_valid = (acc_cnt == CW'(T_ACC));
        hold_load  = data_valid && !valid_q;
    end

endmodule

// File: rtl/fmc_reset_seq.sv
// Module: fmc_reset_seq
// Filters the hardware reset pin against a minimum low width. It sequences
// the reset-active, post-reset recovery and internal ready-completion
// windows. The completion length is chosen by whether the embedded engine
// was busy on the edge that validated the pulse.
// Assumes: hw_reset_n is synchronous to clk; all time parameters >= 1.
module fmc_reset_seq #(
    parameter int T_RP       = 4,
    parameter int T_RDY_BUSY = 12,
    parameter int T_RDY_IDLE = 5,
    parameter int T_RH       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_reset_n,
    input  logic engine_busy,
    output logic rst_active,
    output logic recovering,
    output logic int_busy
);

    localparam int RDY_MAX = (T_RDY_BUSY > T_RDY_IDLE) ? T_RDY_BUSY : T_RDY_IDLE;
    localparam int LW      = $clog2(T_RP + 1);
    localparam int RW      = $clog2(RDY_MAX + 1);
    localparam int HW      = $clog2(T_RH + 1);

    logic [LW-1:0] lo_cnt;
    logic [RW-1:0] rdy_cnt;
    logic [HW-1:0] rh_cnt;
    logic          act_q;
    logic          pulse_ok;

    // The current low sample completes the minimum pulse width.
    always_comb pulse_ok = !hw_reset_n && !act_q && (lo_cnt == LW'(T_RP - 1));

    // Count consecutive low samples of the pin, saturating at the minimum width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
        end else if (hw_reset_n) begin
            lo_cnt <= '0;
        end else if (lo_cnt != LW'(T_RP)) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // Hold the reset-active state from validation until the pin returns high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (pulse_ok) begin
            act_q <= 1'b1;
        end else if (hw_reset_n) begin
            act_q <= 1'b0;
        end
    end

    // Run the recovery window after a valid pulse ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rh_cnt <= '0;
        end else if (hw_reset_n && act_q) begin
            rh_cnt <= HW'(T_RH);
        end else if (rh_cnt != '0) begin
            rh_cnt <= rh_cnt - 1'b1;
        end
    end

    // Time internal reset completion, longer if an operation was aborted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_cnt <= '0;
        end else if (pulse_ok) begin
            rdy_cnt <= engine_busy ? RW'(T_RDY_BUSY) : RW'(T_RDY_IDLE);
        end else if (rdy_cnt != '0) begin
            rdy_cnt <= rdy_cnt - 1'b1;
        end
    end

    // Expose the sequencing state.
    always_comb begin
        rst_active = act_q;
        recovering = (rh_cnt != '0);
        int_busy   = (rdy_cnt != '0);
    end

endmodule

// File: rtl/fmc_mode_dec.sv
// Module: fmc_mode_dec
// Purely combinational decode of the operating mode and the bus-side
// enables. Priority: reset, recovery, standby, sleep, active. A deselected
// device with a running engine stays active.
// Assumes: all inputs are registered state or synchronous bus inputs.
module fmc_mode_dec
    import fmc_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    input  logic      hw_reset_n,
    input  logic      engine_busy,
    input  logic      rst_active,
    input  logic      recovering,
    input  logic      int_busy,
    input  logic      sleep_hit,
    output fmc_mode_e mode,
    output logic      rd_sel,
    output logic      dout_oe,
    output logic      wr_accept,
    output logic      ready
);

    logic rd_block;

    // Reads are refused while the pin is low, in reset and during recovery.
    always_comb rd_block = !hw_reset_n || rst_active || recovering;

    // Select the mode by fixed priority.
    always_comb begin
        if (rst_active) begin
            mode = FMC_RESET;
        end else if (recovering) begin
            mode = FMC_RECOVER;
        end else if (ce_n && !engine_busy) begin
            mode = FMC_STANDBY;
        end else if (sleep_hit && !ce_n) begin
            mode = FMC_SLEEP;
        end else begin
            mode = FMC_ACTIVE;
        end
    end

    // Form the data, write and ready outputs.
    always_comb begin
        rd_sel    = !ce_n && !rd_block;
        dout_oe   = rd_sel && !oe_n;
        wr_accept = !ce_n && !we_n && hw_reset_n && !rst_active;
        ready     = !engine_busy && !int_busy;
    end

endmodule

// File: rtl/flash_mode_ctrl.sv
// Module: flash_mode_ctrl (top)
// Bus-side mode and hardware-reset controller of a parallel NOR flash.
// It joins the access/sleep monitor, the reset sequencer and the mode
// decoder. cmd_reset holds the command state machine in array-read mode
// while a valid reset pulse is active.
// Assumes: every input is synchronous to clk; time parameters in cycles.
module flash_mode_ctrl #(
    parameter int AW           = 4,
    parameter int T_ACC        = 3,
    parameter int SLEEP_MARGIN = 2,
    parameter int T_RP         = 4,
    parameter int T_RDY_BUSY   = 12,
    parameter int T_RDY_IDLE   = 5,
    parameter int T_RH         = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          hw_reset_n,
    input  logic [AW-1:0] addr,
    input  logic          engine_busy,
    output logic          dout_oe,
    output logic          wr_accept,
    output logic          data_valid,
    output logic          hold_load,
    output logic          ready,
    output logic          cmd_reset,
    output logic [2:0]    mode
);

    import fmc_pkg::*;

    logic      rst_active;
    logic      recovering;
    logic      int_busy;
    logic      sleep_hit;
    logic      rd_sel;
    fmc_mode_e mode_e;

    fmc_access_mon #(
        .AW           (AW),
        .T_ACC        (T_ACC),
        .SLEEP_MARGIN (SLEEP_MARGIN)
    ) access_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .rd_sel     (rd_sel),
        .sleep_hit  (sleep_hit),
        .data_valid (data_valid),
        .hold_load  (hold_load)
    );

    fmc_reset_seq #(
        .T_RP       (T_RP),
        .T_RDY_BUSY (T_RDY_BUSY),
        .T_RDY_IDLE (T_RDY_IDLE),
        .T_RH       (T_RH)
    ) rstseq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_reset_n  (hw_reset_n),
        .engine_busy (engine_busy),
        .rst_active  (rst_active),
        .recovering  (recovering),
        .int_busy    (int_busy)
    );

    fmc_mode_dec dec_i (
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .hw_reset_n  (hw_reset_n),
        .engine_busy (engine_busy),
        .rst_active  (rst_active),
        .recovering  (recovering),
        .int_busy    (int_busy),
        .sleep_hit   (sleep_hit),
        .mode        (mode_e),
        .rd_sel      (rd_sel),
        .dout_oe     (dout_oe),
        .wr_accept   (wr_accept),
        .ready       (ready)
    );

    // Drive the plain-typed mode port and the command reset level.
    always_comb begin
        mode      = mode_e;
        cmd_reset = rst_active;
    end

endmodule

// File: rtl/fmc_checker.sv
// Module: fmc_checker
// Cycle-level properties of flash_mode_ctrl, attached by bind below.
// Keeps its own count of consecutive low samples of the reset pin.
module fmc_checker #(
    parameter int T_RP = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       hw_reset_n,
    input logic       engine_busy,
    input logic       dout_oe,
    input logic       wr_accept,
    input logic       ready,
    input logic       cmd_reset,
    input logic [2:0] mode
);

    logic [7:0] lo_seen;

    // Count consecutive low samples of the reset pin, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_seen <= '0;
        end else if (hw_reset_n) begin
            lo_seen <= '0;
        end else if (lo_seen != 8'hFF) begin
            lo_seen <= lo_seen + 1'b1;
        end
    end

    assert_standby_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dout_oe);

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        engine_busy |-> !ready);

    assert_reset_blocks_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> (!dout_oe && !wr_accept && cmd_reset));

    assert_min_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_reset) |-> (int'(lo_seen) >= T_RP));

    assert_recover_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |-> !dout_oe);

    assert_oe_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_oe);

    assert_write_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n || !hw_reset_n) |-> !wr_accept);

endmodule

bind flash_mode_ctrl fmc_checker #(.T_RP(T_RP)) checker_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .hw_reset_n  (hw_reset_n),
    .engine_busy (engine_busy),
    .dout_oe     (dout_oe),
    .wr_accept   (wr_accept),
    .ready       (ready),
    .cmd_reset   (cmd_reset),
    .mode        (mode)
);

// File: tb/flash_mode_ctrl_tb_top.sv
// Bench for flash_mode_ctrl: sweeps reset pulse widths and hold lengths of
// the address, with cycle expectations derived from the parameters.
module flash_mode_ctrl_tb_top;

    localparam int AW         = 4;
    localparam int T_ACC      = 3;
    localparam int SLP_MARGIN = 2;
    localparam int T_RP       = 4;
    localparam int T_RDY_B    = 12;
    localparam int T_RDY_I    = 5;
    localparam int T_RH       = 3;
    localparam int SLEEP_CYC  = T_ACC + SLP_MARGIN;
    localparam int RDY_MAX    = (T_RDY_B > T_RDY_I) ? T_RDY_B : T_RDY_I;
    localparam int M_ACT = 0, M_STBY = 1, M_SLP = 2, M_RST = 3, M_REC = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, we_n, hw_reset_n, engine_busy;
    logic [AW-1:0] addr;
    logic          dout_oe, wr_accept, data_valid, hold_load, ready, cmd_reset;
    logic [2:0]    mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    flash_mode_ctrl #(
        .AW (AW), .T_ACC (T_ACC), .SLEEP_MARGIN (SLP_MARGIN), .T_RP (T_RP),
        .T_RDY_BUSY (T_RDY_B), .T_RDY_IDLE (T_RDY_I), .T_RH (T_RH)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
        .hw_reset_n (hw_reset_n), .addr (addr), .engine_busy (engine_busy),
        .dout_oe (dout_oe), .wr_accept (wr_accept), .data_valid (data_valid),
        .hold_load (hold_load), .ready (ready), .cmd_reset (cmd_reset), .mode (mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // R6 R7 R8 R9 R11: one reset pulse of width w, engine busy flag b.
    task automatic run_pulse(input int w, input bit b);
        bit valid = 0;
        int vt = 0;
        int trdy = b ? T_RDY_B : T_RDY_I;
        int lim = (w < T_RP) ? w : T_RP;
        ce_n = 0; oe_n = 0; we_n = 0;
        for (int t = 1; t <= w + RDY_MAX + T_RH + 3; t++) begin
            bit busy_now = b && (t <= lim);
            bit low = (t <= w);
            bit rec;
            engine_busy = busy_now;
            hw_reset_n  = !low;
            addr        = AW'(t);
            tick();
            if (!valid && w >= T_RP && t == T_RP) begin
                valid = 1;
                vt = t;
            end
            rec = valid && !low && (t - w) <= T_RH;
            if (valid && low) chk("R6 mode reset", int'(mode), M_RST);
            else if (rec)     chk("R9 mode recover", int'(mode), M_REC);
            else              chk("R7 no reset mode", int'(mode == 3'd3 || mode == 3'd4), 0);
            chk("R6 R7 cmd_reset", int'(cmd_reset), int'(valid && low));
            chk("R6 R9 dout_oe", int'(dout_oe), int'(!low && !rec));
            chk("R11 wr_accept", int'(wr_accept), int'(!low && !(valid && low)));
            if (rec) chk("R9 data_valid", int'(data_valid), 0);
            chk("R8 ready", int'(ready), int'(!busy_now && (!valid || (t - vt) >= trdy)));
        end
        we_n = 1;
        engine_busy = 0;
        hw_reset_n = 1;
    endtask

    // R3 R4 R10: hold a fresh address and follow sleep entry.
    task automatic run_hold(input logic [AW-1:0] a, input bit oe_hi, input bit wtog);
        ce_n = 0; oe_n = oe_hi; hw_reset_n = 1; engine_busy = 0;
        addr = a;
        for (int j = 1; j <= SLEEP_CYC + 3; j++) begin
            if (wtog) we_n = j[0];
            tick();
            chk("R3 mode", int'(mode), (j - 1 >= SLEEP_CYC) ? M_SLP : M_ACT);
            chk("R4 data_valid", int'(data_valid), int'(j - 1 >= T_ACC));
            chk("R4 hold_load", int'(hold_load), int'(j - 1 == T_ACC));
            chk("R10 dout_oe", int'(dout_oe), int'(!oe_hi));
        end
        we_n = 1;
    endtask

    initial begin
        rst_n = 0; ce_n = 1; oe_n = 0; we_n = 1; hw_reset_n = 1;
        engine_busy = 0; addr = '0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R12: reset state.
        chk("R12 mode standby", int'(mode), M_STBY);
        chk("R12 ready", int'(ready), 1);
        chk("R12 cmd_reset", int'(cmd_reset), 0);
        chk("R1 dout_oe", int'(dout_oe), 0);
        ce_n = 0; #1;
        chk("R12 mode active", int'(mode), M_ACT);

        // R3 R4 R10 sweep over addresses, output enable and write toggling.
        for (int k = 0; k < 6; k++) run_hold(AW'(k + 1), k[0], k[1]);

        // R1: deselect in sleep, both output-enable levels.
        oe_n = 0; ce_n = 1; #1;
        chk("R1 mode standby", int'(mode), M_STBY);
        chk("R1 dout_oe oe low", int'(dout_oe), 0);
        oe_n = 1; #1;
        chk("R1 dout_oe oe high", int'(dout_oe), 0);
        oe_n = 0;
        tick(); tick();
        // R5: reselect, sleep still held, access after T_ACC edges.
        ce_n = 0; #1;
        chk("R5 mode sleep on reselect", int'(mode), M_SLP);
        chk("R5 data_valid at reselect", int'(data_valid), 0);
        for (int k = 1; k <= T_ACC + 1; k++) begin
            tick();
            chk("R5 data_valid", int'(data_valid), int'(k >= T_ACC));
        end

        // R2: deselected with running engine.
        ce_n = 1; engine_busy = 1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R2 mode active", int'(mode), M_ACT);
            chk("R2 ready", int'(ready), 0);
        end
        engine_busy = 0; #1;
        chk("R2 mode standby", int'(mode), M_STBY);
        chk("R2 ready", int'(ready), 1);
        tick();

        // R6 R7 R8 R9 R11: pulse width sweep, idle and busy.
        for (int w = 1; w <= T_RP + 2; w++) begin
            run_pulse(w, 1'b0);
            run_pulse(w, 1'b1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule